// File: doc/BRIEF.md
# Bonded Multi-Lane Transmit Sequencer

This block sits between a word source and twelve per-lane transmit FIFOs of a bonded serial link. It holds off every write until all lanes report that they are ready to transmit. It then loads every lane FIFO with framed words while frame bursting is held off on all lanes. Once every FIFO has passed its partially-empty level, it opens bursting on all lanes in the same cycle, so the lanes leave their FIFOs aligned. From then on it writes only while no lane reports full.

The word source sees one ready output. A word is taken from the source in exactly the cycles in which the block asserts data-valid toward the lanes. The wide data bus and the control-character bus pass through to the lanes unchanged. Every lane writes the same number of words, so the lanes stay in lockstep.

Top module: `txbond_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `tx_valid` and `tx_burst` are all zeros.
- R2: No bit of `tx_valid` or `tx_burst` is set unless every bit of `lane_rdy` is 1. A missing ready on even one lane keeps the block waiting.
- R3: In the cycle after all lanes are first seen ready, the block is loading: `tx_valid` is all ones and `tx_burst` is all zeros, provided no lane is full.
- R4: Loading ends only in a cycle where every bit of `lane_pempty` and every bit of `lane_empty` is 0. While any one of those bits is 1, `tx_burst` stays all zeros.
- R5: In the cycle after loading ends, every bit of `tx_burst` becomes 1 in the same cycle. `tx_burst` is only ever all zeros or all ones.
- R6: Once bursting is enabled, `tx_valid` is all ones when no lane is full. When any single `lane_full` bit is 1, `tx_valid` is all zeros in that same cycle. The same stall applies while loading.
- R7: `src_rdy` equals every bit of `tx_valid` in every cycle.
- R8: If any `lane_rdy` bit drops, `tx_valid` and `tx_burst` go to all zeros in that same cycle. The block then restarts: it waits for all lanes, then loads again, and bursting stays off until the loading condition of R4 is met once more.
- R9: `tx_data` equals `src_data`, and `tx_ctrl` equals `src_ctrl`. Lane n uses bits [64n+63:64n] of the data bus and bits [3n+2:3n] of the control bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| lane_rdy | input | 12 | Per-lane transmit ready |
| lane_full | input | 12 | Per-lane FIFO full flag |
| lane_empty | input | 12 | Per-lane FIFO empty flag |
| lane_pempty | input | 12 | Per-lane FIFO partially-empty flag |
| src_data | input | 768 | Source words, 64 bits per lane |
| src_ctrl | input | 36 | Source control characters, 3 bits per lane |
| src_rdy | output | 1 | Source advances one word when high |
| tx_data | output | 768 | Words to the lane FIFOs |
| tx_ctrl | output | 36 | Control characters to the lane FIFOs |
| tx_valid | output | 12 | Per-lane FIFO write enable |
| tx_burst | output | 12 | Per-lane frame burst enable |

## Verification
The bench builds the block with its default parameters: twelve lanes of 64 data bits and 3 control bits. This covers the full 768-bit and 36-bit buses, and it lets single-lane patterns in the highest and lowest lane stall or hold back all twelve. One closed-loop run gives each lane FIFO model its own partially-empty threshold and its own drain rhythm. The last lane to fill then decides when bursting opens, and full flags arrive on different lanes at different times. In that run the bench checks that no lane is written while full and that the per-lane write counts stay equal.

// File: rtl/txbond_pkg.sv
package txbond_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_RDY = 2'd0,
    ST_LOAD     = 2'd1,
    ST_OPEN     = 2'd2,
    ST_RUN      = 2'd3
  } seq_state_t;
endpackage

// File: rtl/txbond_rst_sync.sv
module txbond_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/txbond_flags.sv
module txbond_flags #(
  parameter int LANES = 12
) (
  input  logic [LANES-1:0] lane_rdy,
  input  logic [LANES-1:0] lane_full,
  input  logic [LANES-1:0] lane_empty,
  input  logic [LANES-1:0] lane_pempty,
  output logic             all_rdy,
  output logic             any_full,
  output logic             all_loaded
);
  logic [LANES-1:0] lane_loaded;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_loaded[l] = ~lane_pempty[l] & ~lane_empty[l];
  end

  assign all_rdy    = &lane_rdy;
  assign any_full   = |lane_full;
  assign all_loaded = &lane_loaded;
endmodule

// File: rtl/txbond_fsm.sv
module txbond_fsm
  import txbond_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       all_rdy,
  input  logic       all_loaded,
  output seq_state_t state
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!all_rdy) begin
      state_d = ST_WAIT_RDY;
    end else begin
      case (state_q)
        ST_WAIT_RDY: state_d = ST_LOAD;
        ST_LOAD:     if (all_loaded) state_d = ST_OPEN;
        ST_OPEN:     state_d = ST_RUN;
        ST_RUN:      state_d = ST_RUN;
        default:     state_d = ST_WAIT_RDY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT_RDY;
    else        state_q <= state_d;
  end

  assign state = state_q;

  AST_OPEN_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPEN) |-> ($past(state_q) == ST_LOAD)); // R5
  AST_LOAD_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_WAIT_RDY && state_q != ST_WAIT_RDY) |-> (state_q == ST_LOAD)); // R8
endmodule

// File: rtl/txbond_drive.sv
module txbond_drive
  import txbond_pkg::*;
#(
  parameter int LANES   = 12,
  parameter int LANE_DW = 64,
  parameter int LANE_CW = 3,
  localparam int DATA_W = LANES * LANE_DW,
  localparam int CTRL_W = LANES * LANE_CW
) (
  input  seq_state_t        state,
  input  logic              all_rdy,
  input  logic              any_full,
  input  logic [DATA_W-1:0] src_data,
  input  logic [CTRL_W-1:0] src_ctrl,
  output logic              src_rdy,
  output logic [DATA_W-1:0] tx_data,
  output logic [CTRL_W-1:0] tx_ctrl,
  output logic [LANES-1:0]  tx_valid,
  output logic [LANES-1:0]  tx_burst
);
  logic write_en;
  logic burst_en;

  always_comb begin
    write_en = all_rdy && !any_full && (state != ST_WAIT_RDY);
    burst_en = all_rdy && ((state == ST_OPEN) || (state == ST_RUN));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign tx_data[l*LANE_DW +: LANE_DW] = src_data[l*LANE_DW +: LANE_DW];
    assign tx_ctrl[l*LANE_CW +: LANE_CW] = src_ctrl[l*LANE_CW +: LANE_CW];
    assign tx_valid[l] = write_en;
    assign tx_burst[l] = burst_en;
  end

  assign src_rdy = write_en;
endmodule

// File: rtl/txbond_seq.sv
module txbond_seq
  import txbond_pkg::*;
#(
  parameter int LANES   = 12,
  parameter int LANE_DW = 64,
  parameter int LANE_CW = 3,
  localparam int DATA_W = LANES * LANE_DW,
  localparam int CTRL_W = LANES * LANE_CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  lane_rdy,
  input  logic [LANES-1:0]  lane_full,
  input  logic [LANES-1:0]  lane_empty,
  input  logic [LANES-1:0]  lane_pempty,
  input  logic [DATA_W-1:0] src_data,
  input  logic [CTRL_W-1:0] src_ctrl,
  output logic              src_rdy,
  output logic [DATA_W-1:0] tx_data,
  output logic [CTRL_W-1:0] tx_ctrl,
  output logic [LANES-1:0]  tx_valid,
  output logic [LANES-1:0]  tx_burst
);
  logic       rst_sync_n;
  logic       all_rdy;
  logic       any_full;
  logic       all_loaded;
  seq_state_t state;

  txbond_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  txbond_flags #(.LANES(LANES)) u_flags (
    .lane_rdy    (lane_rdy),
    .lane_full   (lane_full),
    .lane_empty  (lane_empty),
    .lane_pempty (lane_pempty),
    .all_rdy     (all_rdy),
    .any_full    (any_full),
    .all_loaded  (all_loaded)
  );

  txbond_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .all_rdy    (all_rdy),
    .all_loaded (all_loaded),
    .state      (state)
  );

  txbond_drive #(
    .LANES   (LANES),
    .LANE_DW (LANE_DW),
    .LANE_CW (LANE_CW)
  ) u_drive (
    .state    (state),
    .all_rdy  (all_rdy),
    .any_full (any_full),
    .src_data (src_data),
    .src_ctrl (src_ctrl),
    .src_rdy  (src_rdy),
    .tx_data  (tx_data),
    .tx_ctrl  (tx_ctrl),
    .tx_valid (tx_valid),
    .tx_burst (tx_burst)
  );

  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|lane_full) |-> (tx_valid == '0)); // R6
  AST_NO_OUT_UNREADY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(&lane_rdy)) |-> (tx_valid == '0 && tx_burst == '0)); // R2
  AST_BURST_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_burst == '0) || (&tx_burst)); // R5
  AST_LOAD_NO_BURST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_LOAD) |-> (tx_burst == '0)); // R4
  AST_BURST_RISE_LOADED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(tx_burst[0]) |-> ($past(all_loaded) && state == ST_OPEN)); // R4
  AST_SRC_MIRROR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (src_rdy == tx_valid[LANES-1]) && (src_rdy == tx_valid[0])); // R7
endmodule

// File: tb/txbond_seq_bench.sv
module txbond_seq_bench;
  localparam int L  = 12;
  localparam int DW = 64;
  localparam int CW = 3;
  localparam int NV = 15;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [L-1:0] lane_rdy, lane_full, lane_empty, lane_pempty;
  logic [L*DW-1:0] src_data, tx_data;
  logic [L*CW-1:0] src_ctrl, tx_ctrl;
  logic src_rdy;
  logic [L-1:0] tx_valid, tx_burst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  txbond_seq u_txbond_seq (
    .clk(clk), .rst_n(rst_n), .lane_rdy(lane_rdy), .lane_full(lane_full),
    .lane_empty(lane_empty), .lane_pempty(lane_pempty), .src_data(src_data),
    .src_ctrl(src_ctrl), .src_rdy(src_rdy), .tx_data(tx_data), .tx_ctrl(tx_ctrl),
    .tx_valid(tx_valid), .tx_burst(tx_burst)
  );

  // rdy, full, pempty, empty, exp_valid, exp_burst
  localparam logic [49:0] VEC [NV] = '{
    {12'h000, 12'h000, 12'hFFF, 12'hFFF, 1'b0, 1'b0}, // R2 none ready
    {12'h7FF, 12'h000, 12'hFFF, 12'hFFF, 1'b0, 1'b0}, // R2 top lane missing
    {12'hFFF, 12'h000, 12'hFFF, 12'hFFF, 1'b0, 1'b0}, // R2 seen ready this cycle
    {12'hFFF, 12'h000, 12'hFFF, 12'hFFF, 1'b1, 1'b0}, // R3 loading
    {12'hFFF, 12'h000, 12'h0F0, 12'h000, 1'b1, 1'b0}, // R4 some pempty
    {12'hFFF, 12'h000, 12'h000, 12'h004, 1'b1, 1'b0}, // R4 one empty
    {12'hFFF, 12'h000, 12'h800, 12'h000, 1'b1, 1'b0}, // R4 last lane pempty
    {12'hFFF, 12'h001, 12'h000, 12'h000, 1'b0, 1'b0}, // R6 full stalls load
    {12'hFFF, 12'h000, 12'h000, 12'h000, 1'b1, 1'b1}, // R5 burst opens
    {12'hFFF, 12'h800, 12'h000, 12'h000, 1'b0, 1'b1}, // R6 one lane full
    {12'hFFF, 12'h000, 12'h000, 12'h000, 1'b1, 1'b1}, // R6 resume
    {12'hFFE, 12'h000, 12'h000, 12'h000, 1'b0, 1'b0}, // R8 lane 0 drops
    {12'hFFF, 12'h000, 12'h000, 12'h000, 1'b0, 1'b0}, // R8 waiting again
    {12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0}, // R8 reload, pempty held
    {12'hFFF, 12'h000, 12'h000, 12'h000, 1'b1, 1'b0}  // R8 still loading this cycle
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input bit ev, input bit eb, input string tag);
    logic [L-1:0] xv, xb;
    xv = ev ? '1 : '0;
    xb = eb ? '1 : '0;
    chk(tx_valid == xv, {tag, " valid"}, 64'(tx_valid), 64'(xv));
    chk(tx_burst == xb, {tag, " burst"}, 64'(tx_burst), 64'(xb));
    chk(src_rdy == ev, "R7 src_rdy", 64'(src_rdy), 64'(ev));
  endtask

  int wr_cnt [L];
  int fill [L];

  initial begin
    rst_n = 1'b0;
    lane_rdy = '1; lane_full = '0; lane_empty = '1; lane_pempty = '1;
    src_data = '0; src_ctrl = '0;
    #12;
    check_outs(1'b0, 1'b0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    lane_rdy = '0;
    @(negedge clk); #1;
    check_outs(1'b0, 1'b0, "R1 after release");
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {lane_rdy, lane_full, lane_pempty, lane_empty} = VEC[i][49:2];
      #1;
      check_outs(VEC[i][1], VEC[i][0], $sformatf("vec%0d", i));
      @(negedge clk);
    end

    // R9 pass-through
    for (int l = 0; l < L; l++) begin
      src_data[l*DW +: DW] = {32'hA5A50000 + 32'(l), 32'h1234_0000 ^ 32'(l * 77)};
      src_ctrl[l*CW +: CW] = 3'(l);
    end
    #1;
    chk(tx_data == src_data, "R9 data", tx_data[63:0], src_data[63:0]);
    chk(tx_ctrl == src_ctrl, "R9 ctrl", 64'(tx_ctrl), 64'(src_ctrl));
    chk(tx_data[11*DW +: DW] == src_data[11*DW +: DW], "R9 lane11", tx_data[11*DW +: DW], src_data[11*DW +: DW]);

    // closed loop with per-lane FIFO models
    rst_n = 1'b0; lane_rdy = '0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int l = 0; l < L; l++) begin fill[l] = 0; wr_cnt[l] = 0; end
    begin
      bit seen_burst;
      int full_wr;
      int split;
      seen_burst = 1'b0; full_wr = 0; split = 0;
      for (int cyc = 0; cyc < 400; cyc++) begin
        lane_rdy = '1;
        for (int l = 0; l < L; l++) begin
          lane_full[l]   = (fill[l] >= DEPTH);
          lane_empty[l]  = (fill[l] == 0);
          lane_pempty[l] = (fill[l] < 4 + (l % 5));
        end
        #1;
        if (tx_burst != '0 && tx_burst != '1) split++;
        if (!seen_burst && tx_burst != '0) begin
          seen_burst = 1'b1;
          chk(&tx_burst, "R5 all lanes open together", 64'(tx_burst), 64'hFFF);
        end
        for (int l = 0; l < L; l++) begin
          if (tx_valid[l] && lane_full[l]) full_wr++;
          if (tx_valid[l]) begin wr_cnt[l]++; fill[l]++; end
          if (tx_burst[l] && fill[l] > 0 && ((cyc + l) % 3 != 0)) fill[l]--;
        end
        @(negedge clk);
      end
      chk(seen_burst, "R5 burst reached", 64'(seen_burst), 64'd1);
      chk(split == 0, "R5 burst all-or-none", 64'(split), 64'd0);
      chk(full_wr == 0, "R6 no write while full", 64'(full_wr), 64'd0);
      for (int l = 1; l < L; l++)
        chk(wr_cnt[l] == wr_cnt[0], "R6 equal lane counts", 64'(wr_cnt[l]), 64'(wr_cnt[0]));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule